// File: doc/BRIEF.md
# LIN Slave Auto-Baud Rate Unit

This block generates the shared receive/transmit bit clock of a LIN slave. It emits a 16x oversampling tick at `f_clk * 16 / div_active`. `div_active` is a 12-bit fixed-point divider with an 8-bit integer part and a 4-bit fraction, so the bit rate is `f_clk / (16 * div_active/16)`. Software loads a nominal divider in two parts. The fraction is staged first, and writing the integer part commits the whole nominal value to the active divider.

When automatic synchronization is turned on, every break-detected pulse arms a measurement of the synch byte that follows. The block counts system-clock cycles from the first to the fifth falling edge of the receive line. That span is eight bit times, or 128 oversample periods. The count becomes a new divider, rounded to the nearest 1/16, and this replaces the active value. While a measurement is pending, a busy flag holds off the receive state machine.

Software writes take priority over a measurement load that lands in the same cycle. A measurement whose count saturates, or whose result falls outside the divider's range, is dropped.

Top module: `lin_abr_top`

## Requirements
- R1: While and right after reset, `div_active` equals the parameter `RESET_DIV` (default 0x100, i.e. 16.0), `sync_busy` is 0 and `baud_tick` is 0.
- R2: A write with `wr_sel`=1 (fraction) stores `wr_data[3:0]` in the nominal fraction only, and `div_active` does not change.
- R3: A write with `wr_sel`=0 (integer part) sets `div_active` on the next cycle to `{wr_data, nominal fraction}`, with the integer part in bits 11:4.
- R4: `baud_tick` pulses for one cycle at an average rate of 16/`div_active` ticks per clock. A divider below 16 (1.0) is treated as 16, which gives one tick per clock.
- R5: With `auto_en`=1, a `brk_pulse` raises `sync_busy` on the next cycle. The flag stays high until the fifth falling edge of `rxd` after the break has been handled.
- R6: The measured divider is `(D+4)>>3`, where D is the number of clock cycles between the first and the fifth detected falling edge of `rxd`. It is loaded into `div_active` three cycles after `rxd` falls for the fifth time, and `sync_busy` drops in that same cycle.
- R7: The measurement is dropped and `div_active` is left unchanged when D saturates at 32767, or when the result is below 16 or above 4095. The boundary results 16 and 4095 are accepted.
- R8: When an integer-part write and a measurement load fall in the same cycle, the written value wins.
- R9: With `auto_en`=0, break pulses and `rxd` edges are ignored: `sync_busy` stays 0 and `div_active` changes only through writes.
- R10: A break pulse that arrives during a measurement restarts it, and edges seen before that pulse do not count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| rxd | input | 1 | Receive line, idle high, asynchronous |
| brk_pulse | input | 1 | One-cycle pulse from the break detector |
| auto_en | input | 1 | Enables automatic synchronization |
| wr_en | input | 1 | Write strobe for the nominal divider |
| wr_sel | input | 1 | 0: integer part (commits), 1: fraction |
| wr_data | input | 8 | Write data |
| baud_tick | output | 1 | 16x oversampling tick |
| div_active | output | 12 | Divider in use, 8.4 fixed point |
| sync_busy | output | 1 | Measurement pending, receiver held |

## Verification
A register write shows on `div_active` one cycle later, and `sync_busy` rises one cycle after a break. A falling edge on `rxd` crosses a two-stage synchronizer and an edge register, so a measurement load appears on the third clock edge after the bench drives the fifth low level. The bench drives inputs on the falling clock edge and waits at least five cycles after each synch field before it samples. For the priority case it places the write exactly on that third edge. Tick rates are checked by counting ticks over a window of whole divider periods, with a tolerance of one tick for the residue left in the accumulator.

// File: rtl/lin_abr_pkg.sv
package lin_abr_pkg;

    localparam int MANT_W         = 8;
    localparam int FRAC_W         = 4;
    localparam int DIV_W          = MANT_W + FRAC_W;
    localparam int CNT_W          = 15;
    localparam int OVS_LOG2       = 4;
    localparam int SPAN_BITS_LOG2 = 3;
    localparam int FALL_COUNT     = 5;
    localparam int MEAS_SHIFT     = SPAN_BITS_LOG2 + OVS_LOG2 - FRAC_W;
    localparam int EDGE_W         = $clog2(FALL_COUNT);
    localparam logic [DIV_W-1:0] DIV_ONE = DIV_W'(1 << FRAC_W);

    localparam logic SEL_MANT = 1'b0;
    localparam logic SEL_FRAC = 1'b1;

    typedef struct packed {
        logic [MANT_W-1:0] mant;
        logic [FRAC_W-1:0] frac;
    } div_t;

    typedef struct packed {
        logic             valid;
        logic [DIV_W-1:0] value;
    } meas_res_t;

    typedef enum logic [1:0] {
        MS_IDLE,
        MS_ARMED,
        MS_COUNT
    } meas_state_e;

    function automatic meas_res_t cnt_to_div(input logic [CNT_W-1:0] cnt);
        logic [CNT_W:0] rounded;
        meas_res_t      r;
        rounded = ({1'b0, cnt} + (CNT_W+1)'(1 << (MEAS_SHIFT - 1))) >> MEAS_SHIFT;
        r.value = rounded[DIV_W-1:0];
        r.valid = (cnt != '1)
                  && (rounded >= (CNT_W+1)'(DIV_ONE))
                  && (rounded < (CNT_W+1)'(1 << DIV_W));
        return r;
    endfunction

endpackage

// File: rtl/lin_abr_rxsync.sv
module lin_abr_rxsync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic rxd,
    output logic fall
);
    logic [STAGES-1:0] sh;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh   <= '1;
            prev <= 1'b1;
        end else begin
            sh   <= {sh[STAGES-2:0], rxd};
            prev <= sh[STAGES-1];
        end
    end

    assign fall = prev & ~sh[STAGES-1];
endmodule

// File: rtl/lin_abr_measure.sv
module lin_abr_measure
    import lin_abr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             auto_en,
    input  logic             brk,
    input  logic             fall,
    output logic             busy,
    output logic             load,
    output logic [DIV_W-1:0] value
);
    meas_state_e       state;
    logic [EDGE_W-1:0] edges;
    logic [CNT_W-1:0]  cnt;
    logic              last_edge;
    meas_res_t         res;

    assign last_edge = (state == MS_COUNT) && fall && (edges == EDGE_W'(FALL_COUNT - 1));
    assign res       = cnt_to_div(cnt);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= MS_IDLE;
            edges <= '0;
            cnt   <= '0;
        end else if (!auto_en) begin
            state <= MS_IDLE;
        end else if (brk) begin
            state <= MS_ARMED;
            edges <= '0;
            cnt   <= '0;
        end else begin
            case (state)
                MS_ARMED: begin
                    if (fall) begin
                        state <= MS_COUNT;
                        edges <= EDGE_W'(1);
                        cnt   <= CNT_W'(1);
                    end
                end
                MS_COUNT: begin
                    if (cnt != '1) cnt <= cnt + 1'b1;
                    if (fall) begin
                        if (last_edge) state <= MS_IDLE;
                        else           edges <= edges + 1'b1;
                    end
                end
                default: state <= MS_IDLE;
            endcase
        end
    end

    assign busy  = (state != MS_IDLE);
    assign load  = auto_en && !brk && last_edge && res.valid;
    assign value = res.value;
endmodule

// File: rtl/lin_abr_divsel.sv
module lin_abr_divsel
    import lin_abr_pkg::*;
#(
    parameter logic [DIV_W-1:0] RESET_DIV = 12'h100
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [MANT_W-1:0] wr_data,
    input  logic              meas_load,
    input  logic [DIV_W-1:0]  meas_value,
    output div_t              nominal,
    output logic [DIV_W-1:0]  active
);
    logic mant_wr, frac_wr;
    assign mant_wr = wr_en && (wr_sel == SEL_MANT);
    assign frac_wr = wr_en && (wr_sel == SEL_FRAC);

    always_ff @(posedge clk) begin
        if (rst) begin
            nominal <= div_t'(RESET_DIV);
            active  <= RESET_DIV;
        end else begin
            if (frac_wr) nominal.frac <= wr_data[FRAC_W-1:0];
            if (mant_wr) begin
                nominal.mant <= wr_data;
                active       <= {wr_data, nominal.frac};
            end else if (meas_load) begin
                active <= meas_value;
            end
        end
    end
endmodule

// File: rtl/lin_abr_tickgen.sv
module lin_abr_tickgen
    import lin_abr_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);
    localparam int ACC_W = DIV_W + 1;
    localparam logic [ACC_W-1:0] STEP = ACC_W'(DIV_ONE);

    logic [ACC_W-1:0] acc, sum, div_eff;

    assign div_eff = (div < DIV_ONE) ? STEP : {1'b0, div};
    assign sum     = acc + STEP;

    always_ff @(posedge clk) begin
        if (rst) begin
            acc  <= '0;
            tick <= 1'b0;
        end else if (sum >= div_eff) begin
            acc  <= sum - div_eff;
            tick <= 1'b1;
        end else begin
            acc  <= sum;
            tick <= 1'b0;
        end
    end
endmodule

// File: rtl/lin_abr_top.sv
module lin_abr_top
    import lin_abr_pkg::*;
#(
    parameter logic [DIV_W-1:0] RESET_DIV   = 12'h100,
    parameter int               SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              rxd,
    input  logic              brk_pulse,
    input  logic              auto_en,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [MANT_W-1:0] wr_data,
    output logic              baud_tick,
    output logic [DIV_W-1:0]  div_active,
    output logic              sync_busy
);
    logic              rx_fall;
    logic              meas_load;
    logic [DIV_W-1:0]  meas_value;
    div_t              nominal;
    logic [FRAC_W-1:0] nom_frac;

    assign nom_frac = nominal.frac;

    lin_abr_rxsync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk  (clk),
        .rst  (rst),
        .rxd  (rxd),
        .fall (rx_fall)
    );

    lin_abr_measure u_meas (
        .clk     (clk),
        .rst     (rst),
        .auto_en (auto_en),
        .brk     (brk_pulse),
        .fall    (rx_fall),
        .busy    (sync_busy),
        .load    (meas_load),
        .value   (meas_value)
    );

    lin_abr_divsel #(.RESET_DIV(RESET_DIV)) u_div (
        .clk        (clk),
        .rst        (rst),
        .wr_en      (wr_en),
        .wr_sel     (wr_sel),
        .wr_data    (wr_data),
        .meas_load  (meas_load),
        .meas_value (meas_value),
        .nominal    (nominal),
        .active     (div_active)
    );

    lin_abr_tickgen u_tick (
        .clk  (clk),
        .rst  (rst),
        .div  (div_active),
        .tick (baud_tick)
    );
endmodule

// File: rtl/lin_abr_chk.sv
module lin_abr_chk
    import lin_abr_pkg::*;
#(
    parameter logic [DIV_W-1:0] RESET_DIV = 12'h100
) (
    input logic              clk,
    input logic              rst,
    input logic              auto_en,
    input logic              brk_pulse,
    input logic              wr_en,
    input logic              wr_sel,
    input logic [MANT_W-1:0] wr_data,
    input logic [DIV_W-1:0]  div_active,
    input logic              sync_busy,
    input logic [FRAC_W-1:0] nom_frac,
    input logic              meas_load,
    input logic [DIV_W-1:0]  meas_value
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (div_active == RESET_DIV && !sync_busy));

    p_frac_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_FRAC && !meas_load) |=> $stable(div_active));

    // R3 and R8: an integer-part write always decides the next active value
    p_mant_wins_r8: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_sel == SEL_MANT) |=> div_active == {$past(wr_data), $past(nom_frac)});

    p_break_busy_r5: assert property (@(posedge clk) disable iff (rst)
        (auto_en && brk_pulse) |=> sync_busy);

    p_meas_load_r6: assert property (@(posedge clk) disable iff (rst)
        (meas_load && !(wr_en && wr_sel == SEL_MANT)) |=> div_active == $past(meas_value));

    p_meas_range_r7: assert property (@(posedge clk) disable iff (rst)
        meas_load |-> meas_value >= DIV_ONE);

    p_disabled_idle_r9: assert property (@(posedge clk) disable iff (rst)
        !auto_en |=> !sync_busy);
endmodule

bind lin_abr_top lin_abr_chk #(.RESET_DIV(RESET_DIV)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .auto_en    (auto_en),
    .brk_pulse  (brk_pulse),
    .wr_en      (wr_en),
    .wr_sel     (wr_sel),
    .wr_data    (wr_data),
    .div_active (div_active),
    .sync_busy  (sync_busy),
    .nom_frac   (nom_frac),
    .meas_load  (meas_load),
    .meas_value (meas_value)
);

// File: tb/lin_abr_top_tb.sv
`timescale 1ns/1ps
module lin_abr_top_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       rxd = 1'b1;
    logic       brk_pulse = 1'b0;
    logic       auto_en = 1'b0;
    logic       wr_en = 1'b0;
    logic       wr_sel = 1'b0;
    logic [7:0] wr_data = '0;
    logic       baud_tick;
    logic [11:0] div_active;
    logic       sync_busy;

    int checks = 0;
    int fails  = 0;

    always #5 clk = ~clk;

    lin_abr_top u_dut (
        .clk(clk), .rst(rst), .rxd(rxd), .brk_pulse(brk_pulse), .auto_en(auto_en),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .baud_tick(baud_tick), .div_active(div_active), .sync_busy(sync_busy)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0d (0x%0h) expected=%0d (0x%0h)", req, act, act, exp, exp);
        end
    endtask

    task automatic wait_cyc(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic write_reg(input bit sel, input logic [7:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = data;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic send_break();
        @(negedge clk);
        brk_pulse = 1'b1;
        @(negedge clk);
        brk_pulse = 1'b0;
    endtask

    task automatic drive(input logic v, input int len);
        rxd = v;
        wait_cyc(len);
    endtask

    // synch byte 0x55: falls at start, d1, d3, d5, d7; extra lengthens d6
    // collide: put an integer-part write of wdata on the load edge
    task automatic send_field(input int bl, input int extra, input bit collide,
                              input logic [7:0] wdata);
        drive(1'b0, bl);
        for (int b = 0; b < 6; b++) drive((b % 2 == 0) ? 1'b1 : 1'b0, bl);
        drive(1'b1, bl + extra);
        rxd = 1'b0;
        if (collide) begin
            @(negedge clk);
            @(negedge clk);
            wr_en = 1'b1; wr_sel = 1'b0; wr_data = wdata;
            @(negedge clk);
            wr_en = 1'b0;
            wait_cyc(bl - 3);
        end else begin
            wait_cyc(bl);
        end
        drive(1'b1, bl);
        wait_cyc(5);
    endtask

    task automatic rate_check(input string req, input int n, input int div);
        int cnt = 0;
        int eff = (div < 16) ? 16 : div;
        int exp = (16 * n) / eff;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            if (baud_tick) cnt++;
        end
        check(cnt >= exp - 1 && cnt <= exp + 1, req, cnt, exp);
    endtask

    task automatic t_reset();
        wait_cyc(2);
        check(div_active == 12'h100, "R1 div", div_active, 12'h100);
        check(sync_busy == 1'b0, "R1 busy", sync_busy, 0);
        check(baud_tick == 1'b0, "R1 tick", baud_tick, 0);
        rst = 1'b0;
    endtask

    task automatic t_writes_and_rate();
        rate_check("R4 rate 16.0", 1600, 12'h100);
        write_reg(1'b1, 8'hF8);
        wait_cyc(2);
        check(div_active == 12'h100, "R2 fraction only", div_active, 12'h100);
        write_reg(1'b0, 8'h0A);
        check(div_active == 12'h0A8, "R3 commit", div_active, 12'h0A8);
        rate_check("R4 rate 10.5", 1680, 12'h0A8);
        write_reg(1'b1, 8'h00);
        write_reg(1'b0, 8'h00);
        check(div_active == 12'h000, "R3 zero", div_active, 0);
        rate_check("R4 clamp", 100, 0);
        write_reg(1'b0, 8'h10);
        check(div_active == 12'h100, "R3 restore", div_active, 12'h100);
    endtask

    task automatic t_measure();
        auto_en = 1'b1;
        send_break();
        check(sync_busy == 1'b1, "R5 busy after break", sync_busy, 1);
        send_field(200, 0, 1'b0, 8'h00);
        check(div_active == 12'h0C8, "R6 measure 200", div_active, 12'h0C8);
        check(sync_busy == 1'b0, "R5 busy released", sync_busy, 0);
        send_break();
        send_field(200, 3, 1'b0, 8'h00);
        check(div_active == 12'h0C8, "R6 round down", div_active, 12'h0C8);
        send_break();
        send_field(200, 4, 1'b0, 8'h00);
        check(div_active == 12'h0C9, "R6 round up", div_active, 12'h0C9);
        rate_check("R4 rate measured", 2010, 12'h0C9);
    endtask

    task automatic t_range();
        send_break();
        send_field(4100, 0, 1'b0, 8'h00);
        check(div_active == 12'h0C9, "R7 saturate", div_active, 12'h0C9);
        check(sync_busy == 1'b0, "R7 busy after discard", sync_busy, 0);
        send_break();
        send_field(1, 0, 1'b0, 8'h00);
        check(div_active == 12'h0C9, "R7 too small", div_active, 12'h0C9);
        send_break();
        send_field(16, 0, 1'b0, 8'h00);
        check(div_active == 12'h010, "R7 min accepted", div_active, 12'h010);
        send_break();
        send_field(15, 0, 1'b0, 8'h00);
        check(div_active == 12'h010, "R7 below min", div_active, 12'h010);
        send_break();
        send_field(4095, 0, 1'b0, 8'h00);
        check(div_active == 12'hFFF, "R7 max accepted", div_active, 12'hFFF);
    endtask

    task automatic t_disabled();
        auto_en = 1'b0;
        send_break();
        check(sync_busy == 1'b0, "R9 break ignored", sync_busy, 0);
        send_field(100, 0, 1'b0, 8'h00);
        check(div_active == 12'hFFF, "R9 edges ignored", div_active, 12'hFFF);
        check(sync_busy == 1'b0, "R9 still idle", sync_busy, 0);
    endtask

    task automatic t_restart();
        auto_en = 1'b1;
        send_break();
        drive(1'b0, 50); drive(1'b1, 50); drive(1'b0, 50); drive(1'b1, 50);
        check(sync_busy == 1'b1, "R10 busy mid field", sync_busy, 1);
        send_break();
        send_field(120, 0, 1'b0, 8'h00);
        check(div_active == 12'h078, "R10 restarted", div_active, 12'h078);
    endtask

    task automatic t_collide();
        send_break();
        send_field(64, 0, 1'b1, 8'h33);
        check(div_active == 12'h330, "R8 write wins", div_active, 12'h330);
        check(sync_busy == 1'b0, "R8 busy cleared", sync_busy, 0);
    endtask

    initial begin
        wait_cyc(3);
        t_reset();
        t_writes_and_rate();
        t_measure();
        t_range();
        t_disabled();
        t_restart();
        t_collide();
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end

    initial begin
        wait_cyc(180000);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", fails, checks);
        $finish;
    end
endmodule